// File: doc/BRIEF.md
# Address Translation Window Bank

This block holds a set of programmable address-translation windows for a PCIe root port, one set for traffic heading out from the CPU side and an identical set for traffic arriving from the link. Software reaches a single window at a time through a selector register that carries a direction flag and a window number. Through the selector it programs that window's base, limit, target and two control words.

The lookup side is combinational. For a given direction and 64-bit address, the block picks the lowest-numbered enabled window that covers the address. A memory-type window returns the translated address. A configuration-type window returns a configuration request made of a bus number, a device/function byte and a 12-bit register offset. A separate pass-through path supplies the read data for a configuration read, and returns all ones when no device answers.

Programmed values are held in shadow registers. A window's decode only picks them up when its second control word is written, so software can rewrite base, limit and target without the live decode ever seeing a half-updated window.

Top module: `xlate_window_bank`

## Requirements
- R1: The selector register at offset 0x900 holds a window number in bits [3:0] and a direction in bit 31 (1 = inbound, 0 = outbound). It reads back the full 32-bit value last written and resets to 0.
- R2: These per-window registers act on the window named by the selector: control word A at 0x904, control word B at 0x908, base bits [31:0] at 0x90C, base bits [63:32] at 0x910, limit at 0x914, target bits [31:0] at 0x918 and target bits [63:32] at 0x91C. Each reads back the value last written. A write to 0x91C replaces target bits [63:32]. When the selected window number is 4 or more, writes to these offsets are ignored and reads return 0. Reads of any unmapped offset return 0.
- R3: After reset, every window reads base 0, target 0, limit 0xFFFFFFFF and control word A 0. Control word B reads 0, except on inbound window 0 where it reads 0x80000000. Inbound window 0 starts live, so any inbound address from 0 to 0xFFFFFFFF hits it and passes through unchanged.
- R4: Writes to base, limit, target, control word A or the selector do not change the lookup result. A write to control word B loads the window's decode from its current register values.
- R5: A live window is enabled when bit 31 of control word B was set at that load. It covers the addresses from base up to {base[63:32], limit}, with both ends included.
- R6: A hit on a memory-type window (control word A equal to 0 at the load) returns the address target + (address - base), with the config outputs at 0.
- R7: A hit on a configuration-type window (control word A not 0 at the load) raises the config flag. It returns the bus number from target bits [31:24], the device/function from target bits [23:16] and the offset (address - base) bits [11:0]. The translated-address output is 0.
- R8: Switching a window between memory and configuration type and then writing control word B leaves only the new type in effect for that window.
- R9: A lookup considers only the windows of the requested direction (lkDir 1 = inbound). When several of them hit, the lowest window number wins and is reported on lkIdx.
- R10: On a miss, the hit flag, the window number, the config flag and all result fields are 0.
- R11: The configuration read data equals devData while devPresent is 1, and is 0xFFFFFFFF otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 12 | Register offset for reads and writes |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the register at regAddr, combinational |
| lkDir | input | 1 | Lookup direction, 1 = inbound |
| lkAddr | input | 64 | Lookup address |
| lkHit | output | 1 | A live window covers lkAddr |
| lkIdx | output | 2 | Number of the winning window |
| lkIsCfg | output | 1 | Winning window is of configuration type |
| lkXlatAddr | output | 64 | Translated address for a memory-type hit |
| lkCfgBus | output | 8 | Bus number for a configuration hit |
| lkCfgDevFn | output | 8 | Device/function for a configuration hit |
| lkCfgOffset | output | 12 | Register offset for a configuration hit |
| devPresent | input | 1 | A device answered the configuration read |
| devData | input | 32 | Configuration read data from the device |
| cfgRdData | output | 32 | Configuration read data returned to the requester |

## Verification
The decode-stability property assumes that lkAddr and lkDir stay constant over the cycle after a shadow-register write. It only checks the cases where they do, and the directed stimulus holds the lookup inputs still around such writes. The readback property assumes that a selector write is followed by a read at the same offset without another write in between, and the stimulus reads the selector right after writing it. The random phase keeps window bases, limits and lookup addresses in a small range, so hits, misses, overlaps and both window types all occur. It drives each register input only at the falling clock edge.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 64;
  localparam int REG_AW    = 12;
  localparam int CFG_OFF_W = 12;
  localparam int DIR_BIT   = 31;
  localparam int EN_BIT    = 31;

  localparam logic [REG_AW-1:0] OFF_VIEW    = 12'h900;
  localparam logic [REG_AW-1:0] OFF_CTLA    = 12'h904;
  localparam logic [REG_AW-1:0] OFF_CTLB    = 12'h908;
  localparam logic [REG_AW-1:0] OFF_BASE_LO = 12'h90C;
  localparam logic [REG_AW-1:0] OFF_BASE_HI = 12'h910;
  localparam logic [REG_AW-1:0] OFF_LIMIT   = 12'h914;
  localparam logic [REG_AW-1:0] OFF_TGT_LO  = 12'h918;
  localparam logic [REG_AW-1:0] OFF_TGT_HI  = 12'h91C;

  typedef struct packed {
    logic wrCtlA;
    logic wrCtlB;
    logic wrBaseLo;
    logic wrBaseHi;
    logic wrLimit;
    logic wrTgtLo;
    logic wrTgtHi;
  } winStrobe_t;

  typedef enum logic [3:0] {
    RD_NONE, RD_VIEW, RD_CTLA, RD_CTLB, RD_BASE_LO,
    RD_BASE_HI, RD_LIMIT, RD_TGT_LO, RD_TGT_HI
  } rdSel_t;
endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int NumWin = 4,
  localparam int IdxW = (NumWin > 1) ? $clog2(NumWin) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output winStrobe_t        strobe,
  output rdSel_t            rdSel,
  output logic [REG_W-1:0]  viewReg,
  output logic              selDir,
  output logic [IdxW-1:0]   selIdx,
  output logic              selValid
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) viewReg <= '0;
    else if (regWrEn && regAddr == OFF_VIEW) viewReg <= regWrData;
  end

  assign selDir   = viewReg[DIR_BIT];
  assign selIdx   = viewReg[IdxW-1:0];
  assign selValid = (32'(viewReg[3:0]) < NumWin);

  logic winWr;
  assign winWr = regWrEn && selValid;

  always_comb begin
    strobe = '0;
    rdSel  = RD_NONE;
    case (regAddr)
      OFF_VIEW:    rdSel = RD_VIEW;
      OFF_CTLA:    begin rdSel = RD_CTLA;    strobe.wrCtlA   = winWr; end
      OFF_CTLB:    begin rdSel = RD_CTLB;    strobe.wrCtlB   = winWr; end
      OFF_BASE_LO: begin rdSel = RD_BASE_LO; strobe.wrBaseLo = winWr; end
      OFF_BASE_HI: begin rdSel = RD_BASE_HI; strobe.wrBaseHi = winWr; end
      OFF_LIMIT:   begin rdSel = RD_LIMIT;   strobe.wrLimit  = winWr; end
      OFF_TGT_LO:  begin rdSel = RD_TGT_LO;  strobe.wrTgtLo  = winWr; end
      OFF_TGT_HI:  begin rdSel = RD_TGT_HI;  strobe.wrTgtHi  = winWr; end
      default:     rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/xlate_dp.sv
module xlate_dp
  import xlate_pkg::*;
#(
  parameter int NumWin = 4,
  localparam int IdxW = (NumWin > 1) ? $clog2(NumWin) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  winStrobe_t           strobe,
  input  logic [REG_W-1:0]     wrData,
  input  logic                 selDir,
  input  logic [IdxW-1:0]      selIdx,
  input  rdSel_t               rdSel,
  output logic [REG_W-1:0]     winRd,
  input  logic                 lkDir,
  input  logic [ADDR_W-1:0]    lkAddr,
  output logic                 lkHit,
  output logic [IdxW-1:0]      lkIdx,
  output logic                 lkIsCfg,
  output logic [ADDR_W-1:0]    lkXlatAddr,
  output logic [7:0]           lkCfgBus,
  output logic [7:0]           lkCfgDevFn,
  output logic [CFG_OFF_W-1:0] lkCfgOffset
);
  // shadow (programmed) registers
  logic [ADDR_W-1:0] pBase  [2][NumWin];
  logic [ADDR_W-1:0] pTgt   [2][NumWin];
  logic [REG_W-1:0]  pLimit [2][NumWin];
  logic [REG_W-1:0]  pCtlA  [2][NumWin];
  logic [REG_W-1:0]  pCtlB  [2][NumWin];
  // live decode, loaded on control word B write
  logic              aEn    [2][NumWin];
  logic              aCfg   [2][NumWin];
  logic [ADDR_W-1:0] aBase  [2][NumWin];
  logic [ADDR_W-1:0] aEnd   [2][NumWin];
  logic [ADDR_W-1:0] aTgt   [2][NumWin];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int d = 0; d < 2; d++) begin
        for (int w = 0; w < NumWin; w++) begin
          pBase[d][w]  <= '0;
          pTgt[d][w]   <= '0;
          pLimit[d][w] <= '1;
          pCtlA[d][w]  <= '0;
          pCtlB[d][w]  <= (d == 1 && w == 0) ? (REG_W'(1) << EN_BIT) : '0;
          aEn[d][w]    <= (d == 1 && w == 0);
          aCfg[d][w]   <= 1'b0;
          aBase[d][w]  <= '0;
          aEnd[d][w]   <= {{(ADDR_W-REG_W){1'b0}}, {REG_W{1'b1}}};
          aTgt[d][w]   <= '0;
        end
      end
    end else begin
      for (int d = 0; d < 2; d++) begin
        for (int w = 0; w < NumWin; w++) begin
          if (d == int'(selDir) && w == int'(selIdx)) begin
            if (strobe.wrBaseLo) pBase[d][w][REG_W-1:0]      <= wrData;
            if (strobe.wrBaseHi) pBase[d][w][ADDR_W-1:REG_W] <= wrData;
            if (strobe.wrTgtLo)  pTgt[d][w][REG_W-1:0]       <= wrData;
            if (strobe.wrTgtHi)  pTgt[d][w][ADDR_W-1:REG_W]  <= wrData;
            if (strobe.wrLimit)  pLimit[d][w]                <= wrData;
            if (strobe.wrCtlA)   pCtlA[d][w]                 <= wrData;
            if (strobe.wrCtlB) begin
              pCtlB[d][w] <= wrData;
              aEn[d][w]   <= wrData[EN_BIT];
              aCfg[d][w]  <= (pCtlA[d][w] != '0);
              aBase[d][w] <= pBase[d][w];
              aEnd[d][w]  <= {pBase[d][w][ADDR_W-1:REG_W], pLimit[d][w]};
              aTgt[d][w]  <= pTgt[d][w];
            end
          end
        end
      end
    end
  end

  always_comb begin
    case (rdSel)
      RD_CTLA:    winRd = pCtlA[selDir][selIdx];
      RD_CTLB:    winRd = pCtlB[selDir][selIdx];
      RD_BASE_LO: winRd = pBase[selDir][selIdx][REG_W-1:0];
      RD_BASE_HI: winRd = pBase[selDir][selIdx][ADDR_W-1:REG_W];
      RD_LIMIT:   winRd = pLimit[selDir][selIdx];
      RD_TGT_LO:  winRd = pTgt[selDir][selIdx][REG_W-1:0];
      RD_TGT_HI:  winRd = pTgt[selDir][selIdx][ADDR_W-1:REG_W];
      default:    winRd = '0;
    endcase
  end

  logic [NumWin-1:0] hitVec;
  for (genvar w = 0; w < NumWin; w++) begin : g_hit
    assign hitVec[w] = aEn[lkDir][w] && (lkAddr >= aBase[lkDir][w])
                       && (lkAddr <= aEnd[lkDir][w]);
  end

  logic            found;
  logic [IdxW-1:0] winner;
  always_comb begin
    found  = 1'b0;
    winner = '0;
    for (int w = NumWin - 1; w >= 0; w--) begin
      if (hitVec[w]) begin
        found  = 1'b1;
        winner = IdxW'(w);
      end
    end
  end

  logic [ADDR_W-1:0] offs;
  logic [ADDR_W-1:0] tgtSel;
  logic              cfgSel;
  assign offs   = lkAddr - aBase[lkDir][winner];
  assign tgtSel = aTgt[lkDir][winner];
  assign cfgSel = aCfg[lkDir][winner];

  assign lkHit       = found;
  assign lkIdx       = found ? winner : '0;
  assign lkIsCfg     = found && cfgSel;
  assign lkXlatAddr  = (found && !cfgSel) ? tgtSel + offs : '0;
  assign lkCfgBus    = (found && cfgSel) ? tgtSel[31:24] : '0;
  assign lkCfgDevFn  = (found && cfgSel) ? tgtSel[23:16] : '0;
  assign lkCfgOffset = (found && cfgSel) ? offs[CFG_OFF_W-1:0] : '0;
endmodule

// File: rtl/xlate_window_bank.sv
module xlate_window_bank
  import xlate_pkg::*;
#(
  parameter int NumWin = 4,
  localparam int IdxW = (NumWin > 1) ? $clog2(NumWin) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  logic                 lkDir,
  input  logic [ADDR_W-1:0]    lkAddr,
  output logic                 lkHit,
  output logic [IdxW-1:0]      lkIdx,
  output logic                 lkIsCfg,
  output logic [ADDR_W-1:0]    lkXlatAddr,
  output logic [7:0]           lkCfgBus,
  output logic [7:0]           lkCfgDevFn,
  output logic [CFG_OFF_W-1:0] lkCfgOffset,
  input  logic                 devPresent,
  input  logic [REG_W-1:0]     devData,
  output logic [REG_W-1:0]     cfgRdData
);
  winStrobe_t       strobe;
  rdSel_t           rdSel;
  logic [REG_W-1:0] viewReg;
  logic [REG_W-1:0] winRd;
  logic             selDir;
  logic [IdxW-1:0]  selIdx;
  logic             selValid;

  xlate_ctrl #(.NumWin(NumWin)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .strobe(strobe), .rdSel(rdSel),
    .viewReg(viewReg), .selDir(selDir), .selIdx(selIdx), .selValid(selValid)
  );

  xlate_dp #(.NumWin(NumWin)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .selDir(selDir), .selIdx(selIdx), .rdSel(rdSel), .winRd(winRd),
    .lkDir(lkDir), .lkAddr(lkAddr), .lkHit(lkHit), .lkIdx(lkIdx),
    .lkIsCfg(lkIsCfg), .lkXlatAddr(lkXlatAddr), .lkCfgBus(lkCfgBus),
    .lkCfgDevFn(lkCfgDevFn), .lkCfgOffset(lkCfgOffset)
  );

  assign regRdData = (rdSel == RD_VIEW) ? viewReg
                   : (rdSel == RD_NONE || !selValid) ? '0 : winRd;

  assign cfgRdData = devPresent ? devData : '1;
endmodule

// File: rtl/xlate_window_bank_chk.sv
module xlate_window_bank_chk
  import xlate_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [REG_AW-1:0]    regAddr,
  input logic                 regWrEn,
  input logic [REG_W-1:0]     regWrData,
  input logic [REG_W-1:0]     regRdData,
  input logic                 lkDir,
  input logic [ADDR_W-1:0]    lkAddr,
  input logic                 lkHit,
  input logic                 lkIsCfg,
  input logic [ADDR_W-1:0]    lkXlatAddr,
  input logic [7:0]           lkCfgBus,
  input logic [7:0]           lkCfgDevFn,
  input logic [CFG_OFF_W-1:0] lkCfgOffset
);
  logic shadowWr;
  assign shadowWr = regWrEn && (regAddr == OFF_VIEW || regAddr == OFF_CTLA ||
                    regAddr == OFF_BASE_LO || regAddr == OFF_BASE_HI ||
                    regAddr == OFF_LIMIT || regAddr == OFF_TGT_LO ||
                    regAddr == OFF_TGT_HI);

  // R4
  decode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    shadowWr |=> (!$stable(lkAddr) || !$stable(lkDir) ||
                  ($stable(lkHit) && $stable(lkXlatAddr) && $stable(lkIsCfg))));

  // R1
  view_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFF_VIEW) |=>
      (regAddr != OFF_VIEW || regRdData == $past(regWrData)));

  // R10
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (!lkIsCfg && lkXlatAddr == '0 && lkCfgBus == '0 &&
                lkCfgDevFn == '0 && lkCfgOffset == '0));

  // R7
  cfg_no_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkIsCfg |-> (lkHit && lkXlatAddr == '0));

  // R6
  mem_no_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lkHit && !lkIsCfg) |-> (lkCfgBus == '0 && lkCfgDevFn == '0 &&
                             lkCfgOffset == '0));
endmodule

bind xlate_window_bank xlate_window_bank_chk u_chk (.*);

// File: tb/xlate_window_bank_tb.sv
module xlate_window_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic [11:0] regAddr;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        lkDir;
  logic [63:0] lkAddr;
  logic        lkHit;
  logic [1:0]  lkIdx;
  logic        lkIsCfg;
  logic [63:0] lkXlatAddr;
  logic [7:0]  lkCfgBus;
  logic [7:0]  lkCfgDevFn;
  logic [11:0] lkCfgOffset;
  logic        devPresent;
  logic [31:0] devData;
  logic [31:0] cfgRdData;

  xlate_window_bank u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int    nChk = 0;
  int    nFail = 0;
  int    cyc = 0;
  string curReq = "R3";

  // behavioural model
  logic [63:0] mBase [2][NW];
  logic [63:0] mTgt  [2][NW];
  logic [31:0] mLim  [2][NW];
  logic [31:0] mCa   [2][NW];
  logic [31:0] mCb   [2][NW];
  bit          vEn   [2][NW];
  bit          vCfg  [2][NW];
  logic [63:0] vLo   [2][NW];
  logic [63:0] vHi   [2][NW];
  logic [63:0] vTgt  [2][NW];
  logic [31:0] mView;

  task automatic mReset();
    mView = 0;
    for (int d = 0; d < 2; d++)
      for (int w = 0; w < NW; w++) begin
        mBase[d][w] = 0; mTgt[d][w] = 0; mLim[d][w] = 32'hFFFF_FFFF;
        mCa[d][w] = 0;
        mCb[d][w] = (d == 1 && w == 0) ? 32'h8000_0000 : 0;
        vEn[d][w] = (d == 1 && w == 0); vCfg[d][w] = 0;
        vLo[d][w] = 0; vHi[d][w] = 64'hFFFF_FFFF; vTgt[d][w] = 0;
      end
  endtask

  always @(posedge clk) begin
    if (!rstN) mReset();
    else if (regWrEn) begin
      int d, w;
      d = int'(mView[31]);
      w = int'(mView[3:0]);
      if (regAddr == 12'h900) mView = regWrData;
      else if (w < NW) begin
        case (regAddr)
          12'h904: mCa[d][w] = regWrData;
          12'h90C: mBase[d][w][31:0] = regWrData;
          12'h910: mBase[d][w][63:32] = regWrData;
          12'h914: mLim[d][w] = regWrData;
          12'h918: mTgt[d][w][31:0] = regWrData;
          12'h91C: mTgt[d][w][63:32] = regWrData;
          12'h908: begin
            mCb[d][w] = regWrData;
            vEn[d][w] = regWrData[31];
            vCfg[d][w] = (mCa[d][w] != 0);
            vLo[d][w] = mBase[d][w];
            vHi[d][w] = {mBase[d][w][63:32], mLim[d][w]};
            vTgt[d][w] = mTgt[d][w];
          end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] expRd();
    int d, w;
    d = int'(mView[31]);
    w = int'(mView[3:0]);
    if (regAddr == 12'h900) return mView;
    if (w >= NW) return 0;
    case (regAddr)
      12'h904: return mCa[d][w];
      12'h908: return mCb[d][w];
      12'h90C: return mBase[d][w][31:0];
      12'h910: return mBase[d][w][63:32];
      12'h914: return mLim[d][w];
      12'h918: return mTgt[d][w][31:0];
      12'h91C: return mTgt[d][w][63:32];
      default: return 0;
    endcase
  endfunction

  task automatic compare();
    logic [31:0] eRd, eCfgRd;
    logic        eHit, eIsCfg;
    logic [1:0]  eIdx;
    logic [63:0] eX, off;
    logic [7:0]  eBus, eDf;
    logic [11:0] eOff;
    int d;
    eRd = expRd();
    eCfgRd = devPresent ? devData : 32'hFFFF_FFFF;
    eHit = 0; eIdx = 0; eIsCfg = 0; eX = 0; eBus = 0; eDf = 0; eOff = 0;
    d = int'(lkDir);
    for (int w = 0; w < NW; w++) begin
      if (!eHit && vEn[d][w] && lkAddr >= vLo[d][w] && lkAddr <= vHi[d][w]) begin
        eHit = 1; eIdx = 2'(w);
        off = lkAddr - vLo[d][w];
        if (vCfg[d][w]) begin
          eIsCfg = 1; eBus = vTgt[d][w][31:24]; eDf = vTgt[d][w][23:16];
          eOff = off[11:0];
        end else eX = vTgt[d][w] + off;
      end
    end
    nChk++;
    if ({regRdData, cfgRdData, lkHit, lkIdx, lkIsCfg, lkXlatAddr, lkCfgBus,
         lkCfgDevFn, lkCfgOffset} !==
        {eRd, eCfgRd, eHit, eIdx, eIsCfg, eX, eBus, eDf, eOff}) begin
      nFail++;
      $display("FAIL %s t=%0t rd=%h/%h cfgRd=%h/%h hit=%b/%b idx=%0d/%0d cfg=%b/%b xl=%h/%h bus=%h/%h df=%h/%h off=%h/%h (actual/expected)",
               curReq, $time, regRdData, eRd, cfgRdData, eCfgRd, lkHit, eHit,
               lkIdx, eIdx, lkIsCfg, eIsCfg, lkXlatAddr, eX, lkCfgBus, eBus,
               lkCfgDevFn, eDf, lkCfgOffset, eOff);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] dat);
    regAddr = a; regWrEn = 1; regWrData = dat;
    tick();
    regWrEn = 0;
  endtask

  task automatic rd(input logic [11:0] a);
    regAddr = a;
    tick();
  endtask

  task automatic look(input logic dir, input logic [63:0] a);
    lkDir = dir; lkAddr = a;
    tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nFail++; nChk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    rstN = 0; regAddr = 0; regWrEn = 0; regWrData = 0;
    lkDir = 0; lkAddr = 0; devPresent = 0; devData = 0;
    mReset();
    repeat (3) @(negedge clk);
    rstN = 1;

    // R3: reset values, outbound window 0
    curReq = "R3";
    rd(12'h900); rd(12'h904); rd(12'h908); rd(12'h90C); rd(12'h910);
    rd(12'h914); rd(12'h918); rd(12'h91C);
    look(0, 64'h1234);                       // R10 outbound miss
    look(1, 64'h0000_0000_ABCD_0123);        // inbound pass-through
    look(1, 64'h0000_0000_FFFF_FFFF);
    look(1, 64'h0000_0001_0000_0000);        // beyond limit: miss
    // R1: selector to inbound window 0
    curReq = "R1";
    wr(12'h900, 32'h8000_0000); rd(12'h900);
    curReq = "R3";
    rd(12'h908); rd(12'h914);

    // R2: program outbound window 1
    curReq = "R2";
    wr(12'h900, 32'h0000_0001); rd(12'h900);
    lkDir = 0; lkAddr = 64'h1000_0040;
    wr(12'h90C, 32'h1000_0000);
    wr(12'h910, 32'h0);
    wr(12'h914, 32'h1000_FFFF);
    wr(12'h918, 32'hAB00_0000);
    wr(12'h91C, 32'h0000_0077);
    wr(12'h91C, 32'h0000_0012);              // replaces upper target
    rd(12'h90C); rd(12'h914); rd(12'h918); rd(12'h91C);
    // R4: not live before control B
    curReq = "R4";
    wr(12'h904, 32'h0);
    look(0, 64'h1000_0040);
    wr(12'h908, 32'h8000_0000);
    // R6 / R5
    curReq = "R6";
    look(0, 64'h1000_0040);
    curReq = "R5";
    look(0, 64'h1000_FFFF); look(0, 64'h1001_0000); look(0, 64'h0FFF_FFFF);
    look(0, 64'h1000_0000);

    // R9: overlapping window 0, priority and direction
    curReq = "R9";
    wr(12'h900, 32'h0000_0000);
    wr(12'h90C, 32'h1000_8000);
    wr(12'h914, 32'h1000_8FFF);
    wr(12'h918, 32'h5000_0000);
    wr(12'h908, 32'h8000_0000);
    look(0, 64'h1000_8010); look(0, 64'h1000_9000); look(1, 64'h1000_8010);

    // R7 / R8: window 1 switched to config type
    curReq = "R8";
    wr(12'h900, 32'h0000_0001);
    wr(12'h918, 32'h0310_0000);
    wr(12'h904, 32'h0000_0004);
    look(0, 64'h1000_0123);                  // still memory type
    wr(12'h908, 32'h8000_0000);
    curReq = "R7";
    look(0, 64'h1000_0123); look(0, 64'h1000_1456);
    curReq = "R8";
    wr(12'h904, 32'h0);
    wr(12'h908, 32'h8000_0000);
    look(0, 64'h1000_0123);                  // back to memory type

    // R11: config read data
    curReq = "R11";
    devPresent = 0; devData = 32'h1234_5678; tick();
    devPresent = 1; tick();
    devPresent = 0;

    // R5: disable via control B
    curReq = "R5";
    wr(12'h908, 32'h0000_0000);
    look(0, 64'h1000_0123);

    // R2: out-of-range window number
    curReq = "R2";
    wr(12'h900, 32'h0000_0007);
    wr(12'h90C, 32'hDEAD_0000); rd(12'h90C); rd(12'h800);
    wr(12'h900, 32'h0000_0003); rd(12'h90C);

    // random mix under the model
    curReq = "R5";
    for (int k = 0; k < 600; k++) begin
      int sel;
      logic [31:0] r;
      sel = int'($urandom_range(0, 11));
      r = $urandom;
      lkDir = r[31]; lkAddr = {32'h0, 18'h0, r[13:0]};
      devPresent = r[20]; devData = ~r;
      case (sel)
        0: wr(12'h900, {r[7], 28'h0, r[2:0]});
        1: wr(12'h904, r[3] ? 32'h0 : r);
        2: wr(12'h908, {r[5], r[30:0]});
        3: wr(12'h90C, {18'h0, r[25:12]});
        4: wr(12'h910, r[4] ? r : 32'h0);
        5: wr(12'h914, {18'h0, r[24:11]});
        6: wr(12'h918, r);
        7: wr(12'h91C, r);
        default: rd(12'h900 + 12'(4 * (sel % 8)));
      endcase
    end

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule